// File: doc/BRIEF.md
# Receive FIFO with interrupt status

This block sits between a contactless receiver front end and a host microcontroller. The front end sends a strobe when a frame starts and a strobe when it ends. Between the two it delivers decoded bytes, one per valid cycle, and it can also pulse a framing-error or a CRC-error strobe. The block stores those bytes in a small FIFO. It records what happened in an interrupt status register and drives one interrupt line, so that the host knows when to come and fetch the data.

Short frames raise no interrupt until they end, and then raise a receive-complete interrupt. Long frames raise a fill-threshold interrupt as soon as the FIFO holds nine bytes, before the frame has ended, so the host can drain the FIFO while reception goes on. The threshold interrupt can fire again each time the count climbs back to nine, until the receive-complete interrupt closes the frame.

The host uses a read-only register port with three addresses: the interrupt status register, a FIFO status register that carries the byte count and an overflow bit, and a data port that pops one byte per read. Reading the interrupt status register clears it.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset, the interrupt line is low, the interrupt status register reads 0x00 and the FIFO status register reads 0x00.
- R2: A start-of-frame strobe sets bit 6 of the interrupt status register and does not assert the interrupt line.
- R3: An end-of-frame strobe sets bit 7 (receive complete) and asserts the interrupt line from the next cycle. A frame that leaves 8 or fewer bytes buffered raises no interrupt before its end-of-frame strobe.
- R4: When an accepted byte takes the FIFO count from 8 to 9, bit 5 (threshold) is set and the interrupt line is asserted from the next cycle.
- R5: After the host drains the count below 9, the threshold event fires again each time the count next goes from 8 to 9.
- R6: A CRC-error strobe sets bit 4 and a framing-error strobe sets bit 2. Neither strobe asserts the interrupt line on its own.
- R7: A read of address 0x0C returns the interrupt status register in the same cycle. From the next cycle the flags are cleared and the interrupt line is low, except for events that arrive in the same cycle as the read, which are kept.
- R8: A read of address 0x1C returns the FIFO status: bits 3:0 hold the byte count (at most 12), bit 7 is the overflow flag, and bits 6:4 are zero.
- R9: A read of address 0x1F returns the oldest buffered byte and removes it, so bytes come out in arrival order.
- R10: A read of address 0x1F while the FIFO is empty returns 0x00, and the count stays at 0.
- R11: A byte offered while 12 bytes are buffered, with no pop in the same cycle, is dropped and sets the overflow flag. A later start-of-frame strobe clears the overflow flag, unless a byte is dropped in that same cycle.
- R12: A read of any other address returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe from the front end |
| byte_vld_i | input | 1 | Received byte is valid this cycle |
| byte_i | input | 8 | Received byte |
| eof_i | input | 1 | End-of-frame strobe |
| frame_err_i | input | 1 | Framing-error strobe |
| crc_err_i | input | 1 | CRC-error strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 5 | Host register address |
| host_rdata_o | output | 8 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The hardest situation to reach is a second threshold interrupt inside one frame. It needs the count to reach nine, the host to drain it below nine, and more bytes to arrive before the end of the frame, usually with status reads mixed in. A related hard case is an event that lands in the same cycle as an interrupt-status read, which must not be lost. A directed sequence builds both cases on purpose. After it, a long random phase runs with a fixed seed: byte arrivals are frequent, reads of the data port are sparser, and strobes and register reads come at random. Every cycle is compared with a queue-based model kept in the bench, and this phase also reaches repeated overflow, empty pops and re-arming of the threshold.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Host register addresses
  localparam logic [7:0] ADR_IRQ  = 8'h0C;
  localparam logic [7:0] ADR_STAT = 8'h1C;
  localparam logic [7:0] ADR_DATA = 8'h1F;

  // Interrupt status bit positions
  localparam int B_DONE  = 7;
  localparam int B_SOF   = 6;
  localparam int B_THR   = 5;
  localparam int B_CRC   = 4;
  localparam int B_FRAME = 2;

  // Position of the overflow flag in the FIFO status register
  localparam int B_OVF   = 7;

  // Fill level after one cycle of push/pop activity
  function automatic int fill_after(int cnt, bit push, bit pop);
    return cnt + int'(push) - int'(pop);
  endfunction

  // True when the fill level climbs onto the threshold this cycle
  function automatic bit thr_crossed(int old_cnt, int new_cnt, int thr);
    return (old_cnt == thr - 1) && (new_cnt == thr);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  input  logic          clr_ovf,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          ovf,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          drop_evt
);
  import rxq_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q;
  logic          full;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (int'(cnt_q) == DEPTH);
  assign pop_acc  = pop_req && !empty;
  assign push_acc = push_req && (!full || pop_acc);
  assign drop_evt = push_req && !push_acc;
  assign cnt_d    = CW'(fill_after(int'(cnt_q), push_acc, pop_acc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_acc) wp_q <= ptr_inc(wp_q);
      if (pop_acc)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_d;
      if (drop_evt)     ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wp_q] <= din;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R8: the fill level never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  // R11: a dropped byte leaves the count unchanged and flags overflow
  a_r11_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (cnt_q == $past(cnt_q)) && ovf_q);

  // R10: a pop on an empty FIFO leaves the count at zero
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (cnt_q == '0));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          irq_set,
  input  logic          clr,
  output logic [SW-1:0] flags,
  output logic          irq
);
  import rxq_pkg::*;

  logic [SW-1:0] flags_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (clr ? '0 : flags_q) | set_vec;
      irq_q   <= (clr ? 1'b0 : irq_q) | irq_set;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  // R4: a threshold event shows in the flags and on the line next cycle
  a_r4_thr_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_THR] |=> irq_q && flags_q[B_THR]);

  // R3: end of frame raises the line next cycle
  a_r3_eof_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_DONE] |=> irq_q && flags_q[B_DONE]);

  // R7: a quiet status read clears everything
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == '0 && !irq_set) |=> (flags_q == '0) && !irq_q);

  // R6: with no raising event and no prior request, the line stays low
  a_r6_err_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_set && !irq_q) |=> !irq_q);
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DEPTH  = 12,
  parameter int THRESH = 9,
  parameter int ADDR_W = 5,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              eof_i,
  input  logic              frame_err_i,
  input  logic              crc_err_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [7:0]        host_rdata_o,
  output logic              irq_o
);
  import rxq_pkg::*;

  // Named internal events
  logic          rd_irq, rd_stat, rd_data;
  logic          push_acc, pop_acc, drop_evt;
  logic          thr_evt;
  logic [7:0]    set_vec;
  logic [7:0]    head, flags;
  logic [CW-1:0] count;
  logic          empty, ovf;
  logic [7:0]    stat_word;

  assign rd_irq  = host_rd_i && (host_addr_i == ADDR_W'(ADR_IRQ));
  assign rd_stat = host_rd_i && (host_addr_i == ADDR_W'(ADR_STAT));
  assign rd_data = host_rd_i && (host_addr_i == ADDR_W'(ADR_DATA));

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (byte_vld_i),
    .din      (byte_i),
    .pop_req  (rd_data),
    .clr_ovf  (sof_i),
    .head     (head),
    .count    (count),
    .empty    (empty),
    .ovf      (ovf),
    .push_acc (push_acc),
    .pop_acc  (pop_acc),
    .drop_evt (drop_evt)
  );

  assign thr_evt = thr_crossed(int'(count),
                               fill_after(int'(count), push_acc, pop_acc),
                               THRESH);

  always_comb begin
    set_vec          = '0;
    set_vec[B_SOF]   = sof_i;
    set_vec[B_THR]   = thr_evt;
    set_vec[B_CRC]   = crc_err_i;
    set_vec[B_FRAME] = frame_err_i;
    set_vec[B_DONE]  = eof_i;
  end

  rxq_irq #(.SW(8)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .irq_set (thr_evt || eof_i),
    .clr     (rd_irq),
    .flags   (flags),
    .irq     (irq_o)
  );

  always_comb begin
    stat_word        = 8'(count);
    stat_word[B_OVF] = ovf;
  end

  always_comb begin
    host_rdata_o = 8'h00;
    if (rd_irq)                host_rdata_o = flags;
    else if (rd_stat)          host_rdata_o = stat_word;
    else if (rd_data && !empty) host_rdata_o = head;
  end

  // R5: a threshold event can only happen on an accepted byte
  a_r5_thr_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |-> push_acc && !pop_acc);

  // R9: a data read on a non-empty FIFO lowers the count by one unless a byte enters
  a_r9_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !empty && !byte_vld_i) |=> (count == $past(count) - 1'b1));

  // R12: a read of an unmapped address does not move the count
  a_r12_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !rd_irq && !rd_stat && !rd_data && !byte_vld_i) |=> $stable(count));
endmodule

// File: tb/tb_rx_fifo_irq.sv
module tb_rx_fifo_irq;
  localparam int DEPTH = 12;
  localparam int THR   = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sof, vld, eof, ferr, cerr, rd;
  logic [7:0] din;
  logic [4:0] addr;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;

  // Bench model state
  logic [7:0] mq[$];
  logic [7:0] m_flags;
  logic       m_irq;
  logic       m_ovf;
  logic [7:0] last_rd;

  always #2 clk = ~clk;

  rx_fifo_irq dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(din),
    .eof_i(eof), .frame_err_i(ferr), .crc_err_i(cerr), .host_rd_i(rd),
    .host_addr_i(addr), .host_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [4:0] a);
    if (a == 5'h0C) return m_flags;
    if (a == 5'h1C) return {m_ovf, 3'b000, 4'(mq.size())};
    if (a == 5'h1F) return (mq.size() > 0) ? mq[0] : 8'h00;
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [4:0] a);
    if (a == 5'h0C) return "R7";
    if (a == 5'h1C) return "R8";
    if (a == 5'h1F) return (mq.size() > 0) ? "R9" : "R10";
    return "R12";
  endfunction

  // One cycle: drive at negedge, check read data, update model at posedge, check irq
  task automatic step(bit s, bit v, logic [7:0] b, bit e, bit fe, bit ce,
                      bit r, logic [4:0] a);
    int  oldc, newc;
    bit  pop, push, thr;
    logic [7:0] setv;
    sof = s; vld = v; din = b; eof = e; ferr = fe; cerr = ce; rd = r; addr = a;
    #1;
    if (r) begin
      last_rd = rdata;
      chk(tag_of(a), rdata, exp_read(a));
    end
    oldc = mq.size();
    pop  = r && (a == 5'h1F) && (oldc > 0);
    push = v && ((oldc < DEPTH) || pop);
    @(posedge clk);
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back(b);
    newc = mq.size();
    thr  = (oldc == THR - 1) && (newc == THR);
    setv = {e, s, thr, ce, 1'b0, fe, 2'b00};
    m_flags = ((r && a == 5'h0C) ? 8'h00 : m_flags) | setv;
    m_irq   = ((r && a == 5'h0C) ? 1'b0 : m_irq) | thr | e;
    if (v && !push) m_ovf = 1'b1;
    else if (s)     m_ovf = 1'b0;
    #1;
    chk(thr ? "R4" : "R3", {7'd0, irq}, {7'd0, m_irq});
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 8'h00, 0, 0, 0, 0, 5'h00);
  endtask

  task automatic push_byte(logic [7:0] b);
    step(0, 1, b, 0, 0, 0, 0, 5'h00);
  endtask

  task automatic rd_reg(logic [4:0] a);
    step(0, 0, 8'h00, 0, 0, 0, 1, a);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    sof = 0; vld = 0; din = 0; eof = 0; ferr = 0; cerr = 0; rd = 0; addr = 0;
    m_flags = 0; m_irq = 0; m_ovf = 0; last_rd = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", {7'd0, irq}, 8'h00);
    rd_reg(5'h1C); chk("R1", last_rd, 8'h00);
    rd_reg(5'h0C); chk("R1", last_rd, 8'h00);

    // R2: start of frame sets bit 6, line stays low
    step(1, 0, 8'h00, 0, 0, 0, 0, 5'h00);
    chk("R2", {7'd0, irq}, 8'h00);
    rd_reg(5'h0C); chk("R2", last_rd, 8'h40);

    // R3: short frame, no interrupt until end
    for (int i = 0; i < 5; i++) begin
      push_byte(8'hA0 + 8'(i));
      chk("R3", {7'd0, irq}, 8'h00);
    end
    step(0, 0, 8'h00, 1, 0, 0, 0, 5'h00);
    chk("R3", {7'd0, irq}, 8'h01);
    rd_reg(5'h0C); chk("R3", last_rd, 8'h80);
    chk("R7", {7'd0, irq}, 8'h00);

    // R9 / R10: ordered drain then empty read
    for (int i = 0; i < 5; i++) begin
      rd_reg(5'h1F); chk("R9", last_rd, 8'hA0 + 8'(i));
    end
    rd_reg(5'h1F); chk("R10", last_rd, 8'h00);
    rd_reg(5'h1C); chk("R10", last_rd, 8'h00);

    // R4: long frame, threshold at ninth byte
    step(1, 0, 8'h00, 0, 0, 0, 0, 5'h00);
    for (int i = 0; i < 8; i++) push_byte(8'h10 + 8'(i));
    chk("R4", {7'd0, irq}, 8'h00);
    push_byte(8'h18);
    chk("R4", {7'd0, irq}, 8'h01);
    rd_reg(5'h0C); chk("R4", last_rd, 8'h60);

    // R5: drain below threshold, refill to nine fires again
    rd_reg(5'h1F); rd_reg(5'h1F);
    push_byte(8'h19);
    chk("R5", {7'd0, irq}, 8'h00);
    push_byte(8'h1A);
    chk("R5", {7'd0, irq}, 8'h01);
    rd_reg(5'h0C); chk("R5", last_rd, 8'h20);

    // R11: fill to 12 and overflow
    for (int i = 0; i < 4; i++) push_byte(8'h1B + 8'(i));
    rd_reg(5'h1C); chk("R11", last_rd, 8'h8C);

    // R6: errors set flags without the line
    step(0, 0, 8'h00, 0, 1, 1, 0, 5'h00);
    chk("R6", {7'd0, irq}, 8'h00);
    rd_reg(5'h0C); chk("R6", last_rd, 8'h14);

    // R12: unmapped address reads zero, count kept
    rd_reg(5'h05); chk("R12", last_rd, 8'h00);
    rd_reg(5'h1C); chk("R12", last_rd, 8'h8C);

    // R7: event in the same cycle as a status read survives
    step(0, 0, 8'h00, 1, 0, 0, 1, 5'h0C);
    chk("R7", {7'd0, irq}, 8'h01);
    rd_reg(5'h0C); chk("R7", last_rd, 8'h80);

    // R11: next start of frame clears overflow
    step(1, 0, 8'h00, 0, 0, 0, 0, 5'h00);
    rd_reg(5'h1C); chk("R11", last_rd, 8'h0C);
    for (int i = 0; i < 12; i++) rd_reg(5'h1F);
    rd_reg(5'h0C);

    // Random phase against the model
    for (int n = 0; n < 6000; n++) begin
      bit s, v, e, fe, ce, r;
      logic [4:0] a;
      int pick;
      s  = ($urandom_range(99) < 3);
      v  = ($urandom_range(99) < 55);
      e  = ($urandom_range(99) < 3);
      fe = ($urandom_range(99) < 2);
      ce = ($urandom_range(99) < 2);
      r  = ($urandom_range(99) < 45);
      pick = $urandom_range(9);
      if (pick < 5)      a = 5'h1F;
      else if (pick < 7) a = 5'h1C;
      else if (pick < 9) a = 5'h0C;
      else               a = 5'($urandom_range(31));
      step(s, v, 8'($urandom), e, fe, ce, r, a);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule